// File: doc/BRIEF.md
# Mirrored Core-Store Memory Controller

This block sits between a requester and a bank of independent word-storage modules that behave like destructive-readout core. A read empties the addressed cell, so the controller always follows a read with a restore write of the same word inside the same access. The requester raises a one-cycle request with address, write data, a write flag and a mode flag. It sees a one-cycle acknowledge when the access is complete. A read also produces a one-cycle data-valid pulse with the word, one cycle before the acknowledge.

Each module is split into equal sectors. The mode flag is taken with each accepted request. In simplex mode, every installed module holds its own data. In duplex mode, modules are used in pairs (2p, 2p+1) that hold identical copies, so only half the capacity is addressable. Every stored word carries an odd-parity bit. In duplex mode, a failing primary copy is replaced by a good mirror copy, and that good word is written back to both copies. One sector number is a residual sector that all module addresses share.

The default parameters (4 modules of 16 sectors × 16 words) keep the model small. The same code scales to 8 modules of 16 × 256 words of 28 bits.

Top module: `redund_mem_ctrl`

## Requirements
- R1: The address is {module[2:0], sector[3:0], word[3:0]} with the defaults. A request is taken at a rising edge only while the controller is idle. A write's ack_o is high for the one cycle after the first edge following the accepting edge.
- R2: In simplex mode, the module field selects one installed module, and modules keep independent data. A word written to one module is read back unchanged and does not appear in another module.
- R3: In duplex mode, the pair index is module bits [1:0] and module bit 2 is ignored. A write stores the word in modules 2p and 2p+1, and both copies are visible to later simplex reads.
- R4: An access to an absent module (simplex) or an absent pair (duplex, 2p+1 ≥ module count) gets ack_o together with aerr_o in the cycle right after the accepting edge. Such an access changes no stored word.
- R5: Sector 15 is the residual sector. Any module field maps to module 0 (simplex) or pair 0 (duplex), and it never raises aerr_o.
- R6: Reads do not lose data: the word that is read is written back, so repeated reads return the same value.
- R7: For a read, rvalid_o is high for one cycle, after the second edge following the accepting edge, with rdata_o holding the word. ack_o follows in the next cycle.
- R8: Each word has an odd-parity bit above the data bits. In a duplex read with a failing primary copy and a passing mirror copy, the mirror word is returned, perr_o is not raised, and both copies are rewritten with that word.
- R9: perr_o rises when the only copy (simplex) or both copies (duplex) fail parity. It stays high until reset.
- R10: The request and mode inputs are ignored while an access is in progress. A mid-access request produces no extra ack_o, and a mid-access mode change does not alter where the access goes.
- R11: After reset, ack_o, aerr_o, rvalid_o, perr_o and rdata_o are zero, and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| dup_i | input | 1 | 1 = duplex (mirrored) mode, 0 = simplex |
| addr_i | input | 11 | {module, sector, word} address |
| wdata_i | input | 28 | Write data |
| ack_o | output | 1 | Access complete, one cycle |
| aerr_o | output | 1 | Address error, with ack_o |
| rvalid_o | output | 1 | Read data valid, one cycle |
| rdata_o | output | 28 | Read data, held until the next read |
| perr_o | output | 1 | Sticky uncorrectable parity error |

## Verification
Counted from the accepting edge, an address error is acknowledged after that same edge. A write is acknowledged after the next edge. A read shows rvalid_o after the second edge and ack_o after the third. The driver logs the cycle number of the accepting edge with each expected item. The monitor samples at falling edges and compares the ack cycle, the rvalid cycle, the data and the error flag against those offsets. Parity faults are planted in the storage while the controller is idle, and their effects are then observed only through reads at the ports.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

    // module-select field width: room for up to eight modules
    localparam int MOD_SEL_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_LAT,
        ST_WB
    } mcu_state_e;

endpackage

// File: rtl/mcu_bank.sv
module mcu_bank #(
    parameter int DEPTH = 256,
    parameter int CW    = 29,
    parameter int IW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [IW-1:0] idx_i,
    input  logic [CW-1:0] wd_i,
    output logic [CW-1:0] rd_o
);

    // cleared-after-reset word: zero data with its odd-parity bit set
    localparam logic [CW-1:0] ZERO_WORD = {1'b1, {(CW-1){1'b0}}};

    logic [CW-1:0] cell_q [DEPTH];
    logic [CW-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= ZERO_WORD;
            end
            rd_q <= '0;
        end else begin
            if (rd_i) begin
                rd_q          <= cell_q[idx_i];
                cell_q[idx_i] <= '0;
            end else if (wr_i) begin
                cell_q[idx_i] <= wd_i;
            end
        end
    end

    assign rd_o = rd_q;

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (cell_q[$past(idx_i)] == '0));

    // R6
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_i && wr_i));

endmodule

// File: rtl/mcu_decode.sv
module mcu_decode #(
    parameter int N_MOD    = 4,
    parameter int MSW      = 3,
    parameter int SECT_W   = 4,
    parameter int WORD_W   = 4,
    parameter int RES_SECT = 15,
    localparam int OFF_W   = SECT_W + WORD_W,
    localparam int AW      = MSW + OFF_W
) (
    input  logic [AW-1:0]    addr_i,
    input  logic             dup_i,
    output logic [MSW-1:0]   prim_o,
    output logic [MSW-1:0]   mir_o,
    output logic [OFF_W-1:0] off_o,
    output logic             err_o
);

    logic [MSW-1:0]    mod_sel;
    logic [SECT_W-1:0] sect;
    logic [MSW-2:0]    pair;

    assign mod_sel = addr_i[AW-1 -: MSW];
    assign sect    = addr_i[OFF_W-1 -: SECT_W];
    assign pair    = mod_sel[MSW-2:0];
    assign off_o   = addr_i[OFF_W-1:0];

    always_comb begin
        prim_o = mod_sel;
        mir_o  = mod_sel;
        err_o  = 1'b0;
        if (sect == SECT_W'(RES_SECT)) begin
            prim_o = '0;
            mir_o  = dup_i ? MSW'(1) : '0;
        end else if (dup_i) begin
            prim_o = {pair, 1'b0};
            mir_o  = {pair, 1'b1};
            err_o  = int'({pair, 1'b1}) >= N_MOD;
        end else begin
            err_o  = int'(mod_sel) >= N_MOD;
        end
    end

endmodule

// File: rtl/redund_mem_ctrl.sv
module redund_mem_ctrl
    import mcu_pkg::*;
#(
    parameter int N_MOD      = 4,
    parameter int SECTORS    = 16,
    parameter int SECT_WORDS = 16,
    parameter int DW         = 28,
    parameter int RES_SECT   = SECTORS - 1,
    localparam int AW = MOD_SEL_W + $clog2(SECTORS) + $clog2(SECT_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic          dup_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          ack_o,
    output logic          aerr_o,
    output logic          rvalid_o,
    output logic [DW-1:0] rdata_o,
    output logic          perr_o
);

    localparam int SECT_W = $clog2(SECTORS);
    localparam int WORD_W = $clog2(SECT_WORDS);
    localparam int OFF_W  = SECT_W + WORD_W;
    localparam int DEPTH  = SECTORS * SECT_WORDS;
    localparam int NSLOT  = 2 ** MOD_SEL_W;
    localparam int CW     = DW + 1;

    typedef struct packed {
        mcu_state_e           st;
        logic                 dup;
        logic [MOD_SEL_W-1:0] prim;
        logic [MOD_SEL_W-1:0] mir;
        logic [OFF_W-1:0]     off;
        logic [DW-1:0]        wdata;
        logic [CW-1:0]        hold;
        logic [DW-1:0]        rdata;
        logic                 ack;
        logic                 aerr;
        logic                 rvalid;
        logic                 perr;
    } ctl_t;

    ctl_t q, d;

    logic [MOD_SEL_W-1:0] dec_prim, dec_mir;
    logic [OFF_W-1:0]     dec_off;
    logic                 dec_err;

    mcu_decode #(
        .N_MOD   (N_MOD),
        .MSW     (MOD_SEL_W),
        .SECT_W  (SECT_W),
        .WORD_W  (WORD_W),
        .RES_SECT(RES_SECT)
    ) u_dec (
        .addr_i (addr_i),
        .dup_i  (dup_i),
        .prim_o (dec_prim),
        .mir_o  (dec_mir),
        .off_o  (dec_off),
        .err_o  (dec_err)
    );

    logic [CW-1:0] rdw [NSLOT];
    logic [CW-1:0] wr_word;

    // fresh writes get an odd-parity bit on top; restores reuse the held word
    assign wr_word = (q.st == ST_WR) ? {~^q.wdata, q.wdata} : q.hold;

    for (genvar k = 0; k < NSLOT; k++) begin : g_bank
        if (k < N_MOD) begin : g_on
            logic hit, rd_k, wr_k;
            assign hit  = (q.prim == MOD_SEL_W'(k)) || (q.dup && (q.mir == MOD_SEL_W'(k)));
            assign rd_k = hit && (q.st == ST_RD);
            assign wr_k = hit && ((q.st == ST_WR) || (q.st == ST_WB));
            mcu_bank #(
                .DEPTH(DEPTH),
                .CW   (CW),
                .IW   (OFF_W)
            ) u_bank (
                .clk  (clk),
                .rst_n(rst_n),
                .rd_i (rd_k),
                .wr_i (wr_k),
                .idx_i(q.off),
                .wd_i (wr_word),
                .rd_o (rdw[k])
            );
        end else begin : g_off
            assign rdw[k] = '0;
        end
    end

    logic [CW-1:0] p_w, m_w, pick_w;
    logic          p_ok, m_ok, lost;

    always_comb begin
        p_w    = rdw[q.prim];
        m_w    = rdw[q.mir];
        p_ok   = ^p_w;
        m_ok   = ^m_w;
        pick_w = (!p_ok && q.dup && m_ok) ? m_w : p_w;
        lost   = q.dup ? (!p_ok && !m_ok) : !p_ok;

        d        = q;
        d.ack    = 1'b0;
        d.aerr   = 1'b0;
        d.rvalid = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    if (dec_err) begin
                        d.ack  = 1'b1;
                        d.aerr = 1'b1;
                    end else begin
                        d.dup   = dup_i;
                        d.prim  = dec_prim;
                        d.mir   = dec_mir;
                        d.off   = dec_off;
                        d.wdata = wdata_i;
                        d.st    = we_i ? ST_WR : ST_RD;
                    end
                end
            end
            ST_WR: begin
                d.ack = 1'b1;
                d.st  = ST_IDLE;
            end
            ST_RD: begin
                d.st = ST_LAT;
            end
            ST_LAT: begin
                d.hold   = pick_w;
                d.rdata  = pick_w[DW-1:0];
                d.rvalid = 1'b1;
                d.perr   = q.perr | lost;
                d.st     = ST_WB;
            end
            ST_WB: begin
                d.ack = 1'b1;
                d.st  = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ack_o    = q.ack;
    assign aerr_o   = q.aerr;
    assign rvalid_o = q.rvalid;
    assign rdata_o  = q.rdata;
    assign perr_o   = q.perr;

    // R7
    rv_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> (ack_o && !rvalid_o));

    // R7
    rv_not_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> !ack_o);

    // R4
    aerr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aerr_o |-> ack_o);

    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |=> perr_o);

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> (q.dup == $past(q.dup)));

    // R6
    restore_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LAT) |=> (q.st == ST_WB));

endmodule

// File: tb/sim_redund_mem_ctrl.sv
`timescale 1ns/1ps
module sim_redund_mem_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic        dup_i = 1'b0;
    logic [10:0] addr_i = '0;
    logic [27:0] wdata_i = '0;
    logic        ack_o, aerr_o, rvalid_o, perr_o;
    logic [27:0] rdata_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int pend = 0;
    int rv_cyc = -1;
    logic [27:0] rv_dat = '0;
    bit done = 1'b0;

    bit          q_rd [$];
    bit          q_err [$];
    logic [27:0] q_dat [$];
    int          q_cyc [$];
    string       q_tag [$];

    redund_mem_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .dup_i(dup_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .ack_o(ack_o), .aerr_o(aerr_o),
        .rvalid_o(rvalid_o), .rdata_o(rdata_o), .perr_o(perr_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [10:0] ad(input int m, input int s, input int w);
        logic [2:0] mm = m[2:0];
        logic [3:0] ss = s[3:0];
        logic [3:0] ww = w[3:0];
        return {mm, ss, ww};
    endfunction

    task automatic chk(input string r, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", r, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // driver: issue one access and queue what it should produce
    task automatic acc(input bit we, input bit dup, input logic [10:0] a,
                       input logic [27:0] wd, input logic [27:0] ed,
                       input bit ee, input string tag, input bit meddle);
        int lat;
        @(negedge clk);
        req_i = 1'b1; we_i = we; dup_i = dup; addr_i = a; wdata_i = wd;
        @(posedge clk);
        #1;
        lat = ee ? 0 : (we ? 1 : 3);
        q_rd.push_back(!we); q_err.push_back(ee); q_dat.push_back(ed);
        q_cyc.push_back(cyc + lat); q_tag.push_back(tag);
        pend++;
        @(negedge clk);
        req_i = 1'b0;
        if (meddle) begin
            req_i = 1'b1; we_i = 1'b1; dup_i = ~dup;
            addr_i = ad(2, 6, 6); wdata_i = 28'h5A5A5A5;
            @(negedge clk);
            req_i = 1'b0; dup_i = dup;
        end
        while (pend != 0) @(posedge clk);
    endtask

    // plant a word directly in a module cell while the controller is idle
    task automatic plant(input int m, input int off, input logic [28:0] v);
        @(negedge clk);
        case (m)
            0: u0.g_bank[0].g_on.u_bank.cell_q[off] = v;
            1: u0.g_bank[1].g_on.u_bank.cell_q[off] = v;
            2: u0.g_bank[2].g_on.u_bank.cell_q[off] = v;
            default: u0.g_bank[3].g_on.u_bank.cell_q[off] = v;
        endcase
    endtask

    // monitor: pop expectations as results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (rvalid_o) begin
                rv_cyc = cyc;
                rv_dat = rdata_o;
            end
            if (ack_o) begin
                if (pend == 0) begin
                    chk("R10", "unexpected ack", 1, 0);
                end else begin
                    bit e_rd, e_err;
                    logic [27:0] e_dat;
                    int e_cyc;
                    string e_tag;
                    e_rd = q_rd.pop_front(); e_err = q_err.pop_front();
                    e_dat = q_dat.pop_front(); e_cyc = q_cyc.pop_front();
                    e_tag = q_tag.pop_front();
                    chk(e_tag, "aerr", aerr_o, e_err);
                    chk(e_tag, "ack cycle", cyc, e_cyc);
                    if (e_rd && !e_err) begin
                        chk(e_tag, "rvalid cycle", rv_cyc, e_cyc - 1);
                        chk(e_tag, "rdata", rv_dat, e_dat);
                    end
                    pend--;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk("R1", "watchdog expired", 1, 0);
        summary();
    end

    initial begin
        logic [27:0] z1, z2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "ack", ack_o, 0);
        chk("R11", "aerr", aerr_o, 0);
        chk("R11", "rvalid", rvalid_o, 0);
        chk("R11", "perr", perr_o, 0);
        chk("R11", "rdata", rdata_o, 0);
        acc(0, 0, ad(0, 0, 0), 0, 28'h0, 0, "R11", 0);

        // R1 R2 simplex independence and timing
        acc(1, 0, ad(0, 1, 2), 28'h1234567, 0, 0, "R1", 0);
        acc(1, 0, ad(1, 1, 2), 28'hABCDEF0, 0, 0, "R2", 0);
        acc(1, 0, ad(3, 14, 15), 28'hFFFFFFF, 0, 0, "R2", 0);
        acc(0, 0, ad(0, 1, 2), 0, 28'h1234567, 0, "R2", 0);
        acc(0, 0, ad(1, 1, 2), 0, 28'hABCDEF0, 0, "R7", 0);
        acc(0, 0, ad(3, 14, 15), 0, 28'hFFFFFFF, 0, "R2", 0);
        acc(0, 0, ad(2, 1, 2), 0, 28'h0, 0, "R2", 0);
        // R6 repeated read
        acc(0, 0, ad(0, 1, 2), 0, 28'h1234567, 0, "R6", 0);
        acc(0, 0, ad(0, 1, 2), 0, 28'h1234567, 0, "R6", 0);

        // R4 address errors
        acc(1, 0, ad(4, 1, 2), 28'h0DEAD00, 0, 1, "R4", 0);
        acc(0, 0, ad(7, 2, 3), 0, 0, 1, "R4", 0);
        acc(1, 1, ad(2, 1, 2), 28'h0BEEF00, 0, 1, "R4", 0);
        acc(0, 1, ad(6, 0, 0), 0, 0, 1, "R4", 0);
        acc(0, 0, ad(0, 1, 2), 0, 28'h1234567, 0, "R4", 0);

        // R3 duplex mirroring and ignored top bit
        acc(1, 1, ad(1, 3, 4), 28'h7654321, 0, 0, "R3", 0);
        acc(0, 0, ad(2, 3, 4), 0, 28'h7654321, 0, "R3", 0);
        acc(0, 0, ad(3, 3, 4), 0, 28'h7654321, 0, "R3", 0);
        acc(1, 1, ad(5, 3, 5), 28'h0C0FFEE, 0, 0, "R3", 0);
        acc(0, 1, ad(1, 3, 5), 0, 28'h0C0FFEE, 0, "R3", 0);
        acc(0, 0, ad(3, 3, 5), 0, 28'h0C0FFEE, 0, "R3", 0);

        // R5 residual sector
        acc(1, 0, ad(5, 15, 7), 28'h1111111, 0, 0, "R5", 0);
        acc(0, 0, ad(0, 15, 7), 0, 28'h1111111, 0, "R5", 0);
        acc(1, 1, ad(3, 15, 8), 28'h2222222, 0, 0, "R5", 0);
        acc(0, 0, ad(0, 15, 8), 0, 28'h2222222, 0, "R5", 0);
        acc(0, 0, ad(1, 15, 8), 0, 28'h2222222, 0, "R5", 0);

        // R10 mid-access request and mode change ignored
        acc(1, 0, ad(1, 6, 6), 28'h3333333, 0, 0, "R10", 1);
        acc(0, 0, ad(1, 6, 6), 0, 28'h3333333, 0, "R10", 0);
        acc(0, 0, ad(2, 6, 6), 0, 28'h0, 0, "R10", 0);
        acc(0, 0, ad(3, 6, 6), 0, 28'h0, 0, "R10", 0);

        // R8 primary parity fault repaired from mirror
        acc(1, 1, ad(0, 2, 2), 28'h4444444, 0, 0, "R8", 0);
        z1 = 28'h4444445;
        plant(0, 2 * 16 + 2, {^z1, z1});
        acc(0, 1, ad(0, 2, 2), 0, 28'h4444444, 0, "R8", 0);
        acc(0, 0, ad(0, 2, 2), 0, 28'h4444444, 0, "R8", 0);
        acc(0, 0, ad(1, 2, 2), 0, 28'h4444444, 0, "R8", 0);
        @(negedge clk);
        chk("R8", "perr after repair", perr_o, 0);

        // R9 both copies bad raises sticky error
        acc(1, 1, ad(1, 7, 7), 28'h5555555, 0, 0, "R9", 0);
        z1 = 28'h5555554;
        z2 = 28'h5555557;
        plant(2, 7 * 16 + 7, {^z1, z1});
        plant(3, 7 * 16 + 7, {^z2, z2});
        acc(0, 1, ad(1, 7, 7), 0, z1, 0, "R9", 0);
        @(negedge clk);
        chk("R9", "perr raised", perr_o, 1);
        acc(1, 0, ad(0, 4, 4), 28'h6666666, 0, 0, "R9", 0);
        acc(0, 0, ad(0, 4, 4), 0, 28'h6666666, 0, "R9", 0);
        @(negedge clk);
        chk("R9", "perr sticky", perr_o, 1);

        repeat (4) @(negedge clk);
        chk("R10", "leftover items", pend, 0);
        summary();
    end

endmodule